// File: doc/BRIEF.md
# Event Record Decision Unit

This block sits in the event path of one acquisition channel. For every detected event it decides which parts of the event record go to the downstream formatter: whether the record is kept at all (header and timestamp), whether the computed energy is stored, and whether the waveform trace is stored. It does not buffer or format data. It only produces three decision flags, and a one-cycle valid strobe marks them.

The decision combines the following inputs:
- a good-channel enable;
- a two-bit pile-up policy;
- the pile-up flag of the event;
- a trace-capture enable;
- a large-pulse rule, which drops the trace when the event energy exceeds a programmable limit.

The pile-up policy and the large-pulse rule can each veto the trace. So can the trace-capture enable. A trace is stored only when all of them permit it and the record is kept.

The control path is a two-state machine:
- **ST_IDLE** waits for an event strobe. The transition *IDLE→EMIT* happens on a strobe. With no strobe it stays in *IDLE→IDLE*.
- **ST_EMIT** presents the registered decision for one cycle. It returns through *EMIT→IDLE* when no new strobe arrives. It stays in *EMIT→EMIT* when back-to-back strobes arrive, so every event gets its own valid cycle.

Top module: `evdec_unit`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, `rec_valid`, `rec_keep`, `rec_energy` and `rec_trace` are all 0.
- R2: An `ev_strobe` sampled high at a rising edge makes `rec_valid` high for exactly the following cycle. With strobes on consecutive cycles, `rec_valid` stays high, one cycle per event.
- R3: When `cfg_good` is 0, the event gives `rec_keep`, `rec_energy` and `rec_trace` all 0.
- R4: Policy `cfg_pu_mode`=2'b00 keeps every event. A single event stores its energy. A piled-up event stores no energy.
- R5: Policy 2'b01 keeps single events with energy and trace permitted. It drops piled-up events completely (all flags 0).
- R6: Policy 2'b10 keeps piled-up events with trace permitted and no energy. It keeps single events with energy and no trace.
- R7: Policy 2'b11 keeps only piled-up events, with energy and trace permitted. Single events are dropped completely.
- R8: With `cfg_big_sup`=1, an `ev_energy` strictly greater than `trc_limit` clears `rec_trace`. An energy equal to or below the limit leaves the trace permitted.
- R9: With `cfg_big_sup`=0, `trc_limit` has no effect on any flag.
- R10: With `cfg_trace_en`=0, `rec_trace` is 0 and `rec_keep`/`rec_energy` are unchanged.
- R11: All three flags are 0 whenever `rec_valid` is 0. `rec_energy` or `rec_trace` is never 1 unless `rec_keep` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_strobe | input | 1 | One-cycle event strobe; the other event inputs are valid with it |
| ev_piled | input | 1 | Event is piled up |
| ev_energy | input | EW (16) | Computed event energy, unsigned |
| trc_limit | input | EW (16) | Energy limit for the large-pulse trace rule, unsigned |
| cfg_good | input | 1 | Channel marked good |
| cfg_trace_en | input | 1 | Trace capture enable |
| cfg_pu_mode | input | 2 | Pile-up policy (00, 01, 10, 11 as in R4–R7) |
| cfg_big_sup | input | 1 | Large-pulse trace suppression enable |
| rec_valid | output | 1 | Decision valid, one cycle per event |
| rec_keep | output | 1 | Keep the event record (header, timestamp) |
| rec_energy | output | 1 | Store energy in the record |
| rec_trace | output | 1 | Store trace in the record |

## Verification
Every decision output passes through one register level. The flags and `rec_valid` are therefore due in the cycle right after the edge that samples `ev_strobe`.

The bench drives inputs on falling edges and raises the strobe for one cycle. It reads the outputs at the next falling edge, which is half a cycle after the capturing edge. It then reads them again one cycle later, to confirm that the valid pulse has ended and the flags have cleared.

For back-to-back events, the bench reads each event's flags at the falling edge that follows that event's capture edge.

// File: rtl/evdec_pkg.sv
package evdec_pkg;

    typedef enum logic [1:0] {
        PU_KEEP_ALL    = 2'b00,
        PU_REJECT      = 2'b01,
        PU_PILED_TRACE = 2'b10,
        PU_PILED_ONLY  = 2'b11
    } pu_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } evdec_state_e;

    typedef struct packed {
        logic keep;
        logic energy;
        logic trace;
    } rec_sel_t;

    localparam rec_sel_t REC_NONE = '{keep: 1'b0, energy: 1'b0, trace: 1'b0};

endpackage

// File: rtl/evdec_policy.sv
module evdec_policy
    import evdec_pkg::*;
(
    input  logic     good,
    input  logic     piled,
    input  pu_mode_e mode,
    output rec_sel_t sel
);
    always_comb begin
        sel = REC_NONE;
        if (good) begin
            unique case (mode)
                PU_KEEP_ALL: begin
                    sel.keep   = 1'b1;
                    sel.energy = !piled;
                    sel.trace  = 1'b1;
                end
                PU_REJECT: begin
                    sel.keep   = !piled;
                    sel.energy = !piled;
                    sel.trace  = !piled;
                end
                PU_PILED_TRACE: begin
                    sel.keep   = 1'b1;
                    sel.energy = !piled;
                    sel.trace  = piled;
                end
                PU_PILED_ONLY: begin
                    sel.keep   = piled;
                    sel.energy = piled;
                    sel.trace  = piled;
                end
                default: sel = REC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/evdec_size_gate.sv
module evdec_size_gate #(
    parameter int EW = 16
) (
    input  logic          sup_en,
    input  logic [EW-1:0] energy,
    input  logic [EW-1:0] limit,
    output logic          trace_ok
);
    always_comb begin
        trace_ok = 1'b1;
        if (sup_en && (energy > limit)) begin
            trace_ok = 1'b0;
        end
    end
endmodule

// File: rtl/evdec_unit.sv
module evdec_unit
    import evdec_pkg::*;
#(
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_strobe,
    input  logic          ev_piled,
    input  logic [EW-1:0] ev_energy,
    input  logic [EW-1:0] trc_limit,
    input  logic          cfg_good,
    input  logic          cfg_trace_en,
    input  logic [1:0]    cfg_pu_mode,
    input  logic          cfg_big_sup,
    output logic          rec_valid,
    output logic          rec_keep,
    output logic          rec_energy,
    output logic          rec_trace
);
    evdec_state_e state_q, state_d;
    rec_sel_t     pol_sel, dec_sel, sel_q;
    logic         size_ok;

    evdec_policy u_policy (
        .good  (cfg_good),
        .piled (ev_piled),
        .mode  (pu_mode_e'(cfg_pu_mode)),
        .sel   (pol_sel)
    );

    evdec_size_gate #(.EW(EW)) u_size (
        .sup_en   (cfg_big_sup),
        .energy   (ev_energy),
        .limit    (trc_limit),
        .trace_ok (size_ok)
    );

    // All trace vetoes combine by AND
    always_comb begin
        dec_sel       = pol_sel;
        dec_sel.trace = pol_sel.keep & pol_sel.trace & cfg_trace_en & size_ok;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ev_strobe ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = ev_strobe ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sel_q <= REC_NONE;
        else if (ev_strobe) sel_q <= dec_sel;
        else                sel_q <= REC_NONE;
    end

    assign rec_valid  = (state_q == ST_EMIT);
    assign rec_keep   = sel_q.keep;
    assign rec_energy = sel_q.energy;
    assign rec_trace  = sel_q.trace;
endmodule

// File: rtl/evdec_unit_chk.sv
module evdec_unit_chk #(
    parameter int EW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_strobe,
    input logic          ev_piled,
    input logic [EW-1:0] ev_energy,
    input logic [EW-1:0] trc_limit,
    input logic          cfg_good,
    input logic          cfg_trace_en,
    input logic [1:0]    cfg_pu_mode,
    input logic          cfg_big_sup,
    input logic          rec_valid,
    input logic          rec_keep,
    input logic          rec_energy,
    input logic          rec_trace
);
    a_r2_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ev_strobe |=> rec_valid);

    a_r2_valid_ends: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_strobe |=> !rec_valid);

    a_r3_bad_channel_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_strobe && !cfg_good) |=> (!rec_keep && !rec_energy && !rec_trace));

    a_r5_reject_piled: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_strobe && cfg_pu_mode == 2'b01 && ev_piled) |=> !rec_keep);

    a_r7_single_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_strobe && cfg_pu_mode == 2'b11 && !ev_piled) |=> !rec_keep);

    a_r8_large_pulse_no_trace: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_strobe && cfg_big_sup && (ev_energy > trc_limit)) |=> !rec_trace);

    a_r10_trace_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_strobe && !cfg_trace_en) |=> !rec_trace);

    a_r11_store_needs_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_energy || rec_trace) |-> (rec_keep && rec_valid));

    a_r11_idle_flags_low: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid |-> (!rec_keep && !rec_energy && !rec_trace));
endmodule

bind evdec_unit evdec_unit_chk #(.EW(EW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_strobe    (ev_strobe),
    .ev_piled     (ev_piled),
    .ev_energy    (ev_energy),
    .trc_limit    (trc_limit),
    .cfg_good     (cfg_good),
    .cfg_trace_en (cfg_trace_en),
    .cfg_pu_mode  (cfg_pu_mode),
    .cfg_big_sup  (cfg_big_sup),
    .rec_valid    (rec_valid),
    .rec_keep     (rec_keep),
    .rec_energy   (rec_energy),
    .rec_trace    (rec_trace)
);

// File: tb/evdec_unit_tb.sv
`timescale 1ns/1ps
module evdec_unit_tb;
    localparam int EW = 16;
    localparam int NV = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_strobe = 1'b0;
    logic          ev_piled = 1'b0;
    logic [EW-1:0] ev_energy = '0;
    logic [EW-1:0] trc_limit = '0;
    logic          cfg_good = 1'b0;
    logic          cfg_trace_en = 1'b0;
    logic [1:0]    cfg_pu_mode = 2'b00;
    logic          cfg_big_sup = 1'b0;
    logic          rec_valid, rec_keep, rec_energy, rec_trace;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evdec_unit #(.EW(EW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .ev_piled(ev_piled),
        .ev_energy(ev_energy), .trc_limit(trc_limit), .cfg_good(cfg_good),
        .cfg_trace_en(cfg_trace_en), .cfg_pu_mode(cfg_pu_mode),
        .cfg_big_sup(cfg_big_sup), .rec_valid(rec_valid), .rec_keep(rec_keep),
        .rec_energy(rec_energy), .rec_trace(rec_trace)
    );

    // {req[3:0], good, trace_en, mode[1:0], big_sup, piled, energy[15:0], limit[15:0], keep, energy, trace}
    localparam logic [44:0] TBL [NV] = '{
        {4'd4,  1'b1,1'b1,2'b00,1'b0,1'b0, 16'd100,   16'd50, 3'b111}, // R4 single
        {4'd4,  1'b1,1'b1,2'b00,1'b0,1'b1, 16'd100,   16'd50, 3'b101}, // R4 piled
        {4'd5,  1'b1,1'b1,2'b01,1'b0,1'b0, 16'd100,   16'd50, 3'b111}, // R5 single
        {4'd5,  1'b1,1'b1,2'b01,1'b0,1'b1, 16'd100,   16'd50, 3'b000}, // R5 piled
        {4'd6,  1'b1,1'b1,2'b10,1'b0,1'b0, 16'd100,   16'd50, 3'b110}, // R6 single
        {4'd6,  1'b1,1'b1,2'b10,1'b0,1'b1, 16'd100,   16'd50, 3'b101}, // R6 piled
        {4'd7,  1'b1,1'b1,2'b11,1'b0,1'b0, 16'd100,   16'd50, 3'b000}, // R7 single
        {4'd7,  1'b1,1'b1,2'b11,1'b0,1'b1, 16'd100,   16'd50, 3'b111}, // R7 piled
        {4'd3,  1'b0,1'b1,2'b00,1'b0,1'b0, 16'd100,   16'd50, 3'b000}, // R3
        {4'd3,  1'b0,1'b1,2'b11,1'b0,1'b1, 16'd100,   16'd50, 3'b000}, // R3
        {4'd8,  1'b1,1'b1,2'b00,1'b1,1'b0, 16'd51,    16'd50, 3'b110}, // R8 above
        {4'd8,  1'b1,1'b1,2'b00,1'b1,1'b0, 16'd50,    16'd50, 3'b111}, // R8 equal
        {4'd8,  1'b1,1'b1,2'b00,1'b1,1'b0, 16'd49,    16'd50, 3'b111}, // R8 below
        {4'd9,  1'b1,1'b1,2'b00,1'b0,1'b0, 16'd65535, 16'd0,  3'b111}, // R9
        {4'd10, 1'b1,1'b0,2'b00,1'b0,1'b0, 16'd100,   16'd50, 3'b110}, // R10
        {4'd10, 1'b1,1'b0,2'b11,1'b0,1'b1, 16'd100,   16'd50, 3'b110}  // R10
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,keep,energy,trace} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [44:0] v);
        ev_piled     = v[35];
        cfg_good     = v[40];
        cfg_trace_en = v[39];
        cfg_pu_mode  = v[38:37];
        cfg_big_sup  = v[36];
        ev_energy    = v[34:19];
        trc_limit    = v[18:3];
        ev_strobe    = 1'b1;
    endtask

    function automatic logic [3:0] outs();
        return {rec_valid, rec_keep, rec_energy, rec_trace};
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", outs(), 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", outs(), 4'b0000);

        // Table walk: strobe one cycle, read one cycle later
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            @(negedge clk);
            ev_strobe = 1'b0;
            check($sformatf("R%0d row %0d", TBL[i][44:41], i), outs(), {1'b1, TBL[i][2:0]});
        end

        // R2 / R11: valid is a single pulse; flags clear with it
        @(negedge clk);
        check("R2", outs(), 4'b0000);

        // R9: the same event with a different limit gives the same flags
        @(negedge clk);
        drive({4'd9, 1'b1,1'b1,2'b00,1'b0,1'b0, 16'd200, 16'd10, 3'b111});
        @(negedge clk);
        ev_strobe = 1'b0;
        check("R9", outs(), 4'b1111);

        // R2: back-to-back strobes, one valid cycle each
        @(negedge clk);
        drive(TBL[3]);                // R5 piled -> drop
        @(negedge clk);
        drive(TBL[7]);                // R7 piled -> all
        check("R2 b2b first", outs(), 4'b1000);
        @(negedge clk);
        ev_strobe = 1'b0;
        check("R2 b2b second", outs(), 4'b1111);
        @(negedge clk);
        check("R2 b2b end", outs(), 4'b0000);

        // R1: reset during an emit cycle clears outputs
        drive(TBL[0]);
        @(negedge clk);
        ev_strobe = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1 mid reset", outs(), 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", outs(), 4'b0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule